// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers interrupt events from a set of peripheral sources into a sticky identification register and qualifies each flag with a per-source enable mask. When at least one flagged source is enabled and the CPU is not already servicing an interrupt, it raises one registered request line toward the core. A single in-service bit records that a handler is running. It is set when the core branches to the interrupt vector and cleared by a return-from-interrupt.

Software may also write the in-service bit directly. A handler can narrow the mask to the sources it is willing to be preempted by, clear the in-service bit, and so build its own nesting scheme. A disabled source still records its flag. Software therefore sees every pending event and decides in a fixed order which one to serve; index 0 ranks highest. The block reports the highest-ranking enabled pending source for that purpose. The CPU core, vector fetch and context saving lie outside this block.

Top module: `irq_gate`

## Requirements
- R1: After reset all identification flags are 0, every mask bit is 1, the in-service bit is 0 and the request output is 0.
- R2: An event pulse on a source sets that source's identification flag at the next clock edge, whatever its mask bit is, and the flag stays set until cleared.
- R3: A clear strobe on a source resets its flag at the next edge, except when an event for the same source arrives in the same cycle, in which case the flag is set.
- R4: The request output is registered: after each edge it equals the OR over all sources of (flag AND mask) as held before that edge, gated off when the in-service bit was 1 before that edge.
- R5: A source whose mask bit is 0 never causes a request, even with its flag set.
- R6: A vector-taken strobe sets the in-service bit at the next edge, and while it is 1 no request is raised.
- R7: A return strobe clears the in-service bit at the next edge, unless a vector-taken strobe arrives in the same cycle.
- R8: A software write loads the in-service bit at the next edge when neither the vector-taken nor the return strobe is active. The order of precedence is vector-taken, then return, then software write.
- R9: A mask write loads all mask bits at the next edge, and the new mask reaches the request output one edge later.
- R10: The priority outputs give the lowest index whose flag and mask are both 1, with a valid bit that is 1 only when such an index exists. Both follow the registered state without added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | Per-source event pulses |
| flag_clr | input | N_SRC | Per-source flag clear strobes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | N_SRC | Mask write data, 1 = source enabled |
| insvc_we | input | 1 | Software write enable for the in-service bit |
| insvc_wdata | input | 1 | Software write value for the in-service bit |
| vec_take | input | 1 | Core has branched to the interrupt vector |
| reti | input | 1 | Return-from-interrupt executed |
| irq_req | output | 1 | Registered interrupt request to the core |
| flag_q | output | N_SRC | Identification flags for readback |
| mask_q | output | N_SRC | Mask register for readback |
| insvc_q | output | 1 | In-service bit |
| prio_idx | output | IDX_W | Highest-priority enabled pending source |
| prio_vld | output | 1 | prio_idx is meaningful |

## Verification
Flags, mask and in-service bit change at the first edge after their stimulus. The request output lags that state by one further edge, so it shows the state that held before the edge just taken. The priority outputs follow the registered flags and mask in the same cycle. The bench drives every stimulus on a falling edge and samples on the next falling edge. Each table row's expected request therefore comes from the state of the previous row, while its flags, mask, in-service bit and priority come from the row itself.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Source of the next in-service value, in order of precedence.
    typedef enum logic [1:0] {
        INS_HOLD  = 2'd0,
        INS_ENTER = 2'd1,
        INS_EXIT  = 2'd2,
        INS_SW    = 2'd3
    } ins_cause_e;

    function automatic ins_cause_e pick_cause(logic take, logic ret, logic swe);
        if (take)      return INS_ENTER;
        else if (ret)  return INS_EXIT;
        else if (swe)  return INS_SW;
        return INS_HOLD;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flag_o
);

    typedef struct packed {
        logic [N_SRC-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (set_i[i])
                st_d.flag[i] = 1'b1;
            else if (clr_i[i])
                st_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/irq_ctl_state.sv
module irq_ctl_state
    import irq_gate_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             insvc_we,
    input  logic             insvc_wdata,
    input  logic             vec_take,
    input  logic             reti,
    output logic [N_SRC-1:0] mask_o,
    output logic             insvc_o
);

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic             insvc;
    } ctl_t;

    ctl_t       st_d, st_q;
    ins_cause_e cause;

    always_comb begin
        st_d  = st_q;
        cause = pick_cause(vec_take, reti, insvc_we);
        if (mask_we)
            st_d.mask = mask_wdata;
        case (cause)
            INS_ENTER: st_d.insvc = 1'b1;
            INS_EXIT:  st_d.insvc = 1'b0;
            INS_SW:    st_d.insvc = insvc_wdata;
            default:   st_d.insvc = st_q.insvc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.insvc <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign insvc_o = st_q.insvc;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);

    // Walk from the lowest-ranked source upward so index 0 wins last.
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             insvc_we,
    input  logic             insvc_wdata,
    input  logic             vec_take,
    input  logic             reti,
    output logic             irq_req,
    output logic [N_SRC-1:0] flag_q,
    output logic [N_SRC-1:0] mask_q,
    output logic             insvc_q,
    output logic [IDX_W-1:0] prio_idx,
    output logic             prio_vld
);

    typedef struct packed {
        logic req;
    } top_t;

    top_t             st_d, st_q;
    logic [N_SRC-1:0] qual;

    irq_flag_bank #(.N_SRC(N_SRC)) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_evt),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    irq_ctl_state #(.N_SRC(N_SRC)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .insvc_we    (insvc_we),
        .insvc_wdata (insvc_wdata),
        .vec_take    (vec_take),
        .reti        (reti),
        .mask_o      (mask_q),
        .insvc_o     (insvc_q)
    );

    assign qual = flag_q & mask_q;

    irq_prio_enc #(.N_SRC(N_SRC)) prio_i (
        .pend_i (qual),
        .idx_o  (prio_idx),
        .vld_o  (prio_vld)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = (|qual) && !insvc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_req = st_q.req;

endmodule

module irq_gate_chk #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic [N_SRC-1:0] flag_clr,
    input logic             vec_take,
    input logic             reti,
    input logic             irq_req,
    input logic [N_SRC-1:0] flag_q,
    input logic [N_SRC-1:0] mask_q,
    input logic             insvc_q,
    input logic [IDX_W-1:0] prio_idx,
    input logic             prio_vld
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((flag_q & $past(src_evt)) == $past(src_evt)));

    // R3
    clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((flag_q & $past(flag_clr & ~src_evt)) == '0));

    // R4
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (irq_req == ($past(|(flag_q & mask_q)) && !$past(insvc_q))));

    // R6
    insvc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(vec_take) |-> insvc_q);

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(insvc_q) |-> !irq_req);

    // R7
    insvc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(reti && !vec_take) |-> !insvc_q);

    // R10
    prio_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_vld |-> (flag_q[prio_idx] && mask_q[prio_idx]));

endmodule

bind irq_gate irq_gate_chk #(.N_SRC(N_SRC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .flag_clr (flag_clr),
    .vec_take (vec_take),
    .reti     (reti),
    .irq_req  (irq_req),
    .flag_q   (flag_q),
    .mask_q   (mask_q),
    .insvc_q  (insvc_q),
    .prio_idx (prio_idx),
    .prio_vld (prio_vld)
);

// File: tb/irq_gate_tb.sv
module irq_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int IW = 2;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_evt = '0;
    logic [NS-1:0] flag_clr = '0;
    logic          mask_we = 1'b0;
    logic [NS-1:0] mask_wdata = '0;
    logic          insvc_we = 1'b0;
    logic          insvc_wdata = 1'b0;
    logic          vec_take = 1'b0;
    logic          reti = 1'b0;
    logic          irq_req;
    logic [NS-1:0] flag_q;
    logic [NS-1:0] mask_q;
    logic          insvc_q;
    logic [IW-1:0] prio_idx;
    logic          prio_vld;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_gate #(.N_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .flag_clr(flag_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .insvc_we(insvc_we),
        .insvc_wdata(insvc_wdata), .vec_take(vec_take), .reti(reti),
        .irq_req(irq_req), .flag_q(flag_q), .mask_q(mask_q), .insvc_q(insvc_q),
        .prio_idx(prio_idx), .prio_vld(prio_vld)
    );

    typedef struct packed {
        logic [NS-1:0] evt;
        logic [NS-1:0] clr;
        logic          mwe;
        logic [NS-1:0] mwd;
        logic          iwe;
        logic          iwd;
        logic          vec;
        logic          ret;
        logic [NS-1:0] eflag;
        logic [NS-1:0] emask;
        logic          eins;
        logic          eirq;
    } step_t;

    // Expected values hold after the edge that consumes the row's inputs.
    localparam int NSTEP = 19;
    localparam step_t TBL [NSTEP] = '{
        '{4'b0001, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'hF, 1'b0, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'hF, 1'b0, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 4'hF, 1'b1, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'hF, 1'b1, 1'b0},
        '{4'b0100, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 4'hF, 1'b1, 1'b0},
        '{4'b0000, 4'b0000, 1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 4'h4, 1'b1, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0101, 4'h4, 1'b0, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 4'h4, 1'b0, 1'b1},
        '{4'b0000, 4'b0100, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'h4, 1'b0, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'h4, 1'b0, 1'b0},
        '{4'b1000, 4'b1000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1001, 4'h4, 1'b0, 1'b0},
        '{4'b0000, 4'b0000, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1001, 4'hF, 1'b0, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1001, 4'hF, 1'b0, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1001, 4'hF, 1'b1, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1001, 4'hF, 1'b0, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001, 4'hF, 1'b1, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1001, 4'hF, 1'b0, 1'b0},
        '{4'b0000, 4'b1001, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'hF, 1'b0, 1'b1},
        '{4'b0000, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'hF, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_prio(input string req, input logic [NS-1:0] f, input logic [NS-1:0] m);
        logic [NS-1:0] q;
        int            exp_idx;
        q = f & m;
        exp_idx = -1;
        for (int i = 0; i < NS; i++)
            if (q[i] && exp_idx < 0) exp_idx = i;
        check(req, "prio_vld", int'(prio_vld), (exp_idx >= 0) ? 1 : 0);
        if (exp_idx >= 0)
            check(req, "prio_idx", int'(prio_idx), exp_idx);
    endtask

    task automatic idle_inputs();
        src_evt = '0; flag_clr = '0; mask_we = 1'b0; mask_wdata = '0;
        insvc_we = 1'b0; insvc_wdata = 1'b0; vec_take = 1'b0; reti = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state(input string tag);
        check("R1", {tag, " flag"}, int'(flag_q), 0);
        check("R1", {tag, " mask"}, int'(mask_q), 4'hF);
        check("R1", {tag, " insvc"}, int'(insvc_q), 0);
        check("R1", {tag, " irq"}, int'(irq_req), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: state during and after reset
        do_reset();
        check_reset_state("after reset");

        // Table walk: R2 R3 R4 R6 R7 R8 R9 R10
        for (int s = 0; s < NSTEP; s++) begin
            src_evt = TBL[s].evt; flag_clr = TBL[s].clr;
            mask_we = TBL[s].mwe; mask_wdata = TBL[s].mwd;
            insvc_we = TBL[s].iwe; insvc_wdata = TBL[s].iwd;
            vec_take = TBL[s].vec; reti = TBL[s].ret;
            @(negedge clk);
            idle_inputs();
            check("R2/R3", $sformatf("step %0d flag", s), int'(flag_q), int'(TBL[s].eflag));
            check("R9", $sformatf("step %0d mask", s), int'(mask_q), int'(TBL[s].emask));
            check("R6/R7/R8", $sformatf("step %0d insvc", s), int'(insvc_q), int'(TBL[s].eins));
            check("R4", $sformatf("step %0d irq", s), int'(irq_req), int'(TBL[s].eirq));
            check_prio("R10", TBL[s].eflag, TBL[s].emask);
        end

        // R5: masked source latches its flag yet never requests
        do_reset();
        mask_we = 1'b1; mask_wdata = 4'b1101;
        @(negedge clk);
        idle_inputs();
        src_evt = 4'b0010;
        @(negedge clk);
        idle_inputs();
        check("R5", "masked flag latched", int'(flag_q), 4'b0010);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R5", "masked source no irq", int'(irq_req), 0);
        end
        check("R5", "masked prio_vld", int'(prio_vld), 0);

        // R9: re-enabling the mask lets the held flag request one edge later
        mask_we = 1'b1; mask_wdata = 4'b1111;
        @(negedge clk);
        idle_inputs();
        check("R9", "irq not yet after mask write", int'(irq_req), 0);
        @(negedge clk);
        check("R9", "irq after mask applied", int'(irq_req), 1);
        check("R10", "prio idx single", int'(prio_idx), 1);

        // R10: several pending, lowest index wins; masking it moves the winner
        src_evt = 4'b1100;
        @(negedge clk);
        idle_inputs();
        check("R10", "prio lowest of 1110", int'(prio_idx), 1);
        mask_we = 1'b1; mask_wdata = 4'b1001;
        @(negedge clk);
        idle_inputs();
        check("R10", "prio after masking", int'(prio_idx), 3);
        check("R10", "prio_vld after masking", int'(prio_vld), 1);

        // R1: reset mid-run restores defaults
        vec_take = 1'b1;
        @(negedge clk);
        idle_inputs();
        do_reset();
        check_reset_state("mid-run reset");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule